// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block keeps wall-clock time and date as seven packed-BCD bytes: seconds, minutes, hours, day of week, day of month, month and a two-digit year in the range 2000 to 2099. A sub-second tick input is divided down by a parameterised prescaler. Each time the prescaler completes a second, the seconds byte steps and the carry ripples through every field. Day-of-month wraps by month length, with leap years taken into account.

Software reaches the bytes through a simple register port: a 3-bit index, a write strobe, write data and combinational read data. The hour byte carries its own format bit, so the counter runs either 00 to 23 or 1 to 12 with a PM flag, whichever format software last wrote. An oscillator-off input freezes all counting, and a write-protect input blocks register writes.

Top module: `rtc_calendar_core`

## Requirements
- R1: Register index 0 is seconds, 1 minutes, 2 hours, 3 day-of-week, 4 day-of-month, 5 month and 6 year. Index 7 reads 0x00. After reset the bytes read 00, 00, 00, 01, 01, 01, 00.
- R2: Seconds step once for every SUB_TICKS_PER_SEC cycles in which `sub_tick` is high.
- R3: Seconds wrap 0x59 to 0x00 with a minute carry, and minutes wrap 0x59 to 0x00 with an hour carry. All steps are BCD, so 0x09 becomes 0x10.
- R4: In 24-hour format (hour bit 6 clear), the hour counts 0x00 to 0x23. Stepping past 0x23 gives 0x00 and advances the date.
- R5: In 12-hour format (hour bit 6 set, bit 5 = PM, bits 4:0 = BCD 01..12), the hour steps 12 to 01 without changing PM. It steps 11 AM (0x51) to 12 PM (0x72) with the date unchanged.
- R6: In 12-hour format, 11 PM (0x71) steps to 12 AM (0x52) and the date advances.
- R7: On each date advance, day-of-week steps 1..7 and wraps from 7 to 1.
- R8: Day-of-month wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in every other month except February. Month 0x12 wraps to 0x01 and increments the year, and year 0x99 wraps to 0x00.
- R9: February ends on day 29 when the year value is divisible by 4, and otherwise on day 28.
- R10: While `osc_off` is high, no field and no prescaler phase changes, except through register writes.
- R11: While `wr_protect` is high, register writes have no effect.
- R12: An accepted write loads the addressed byte by the next cycle. A seconds write restarts the sub-second phase; writes to any other byte leave the phase alone.
- R13: Values that are not legal BCD are stored and read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | One-cycle sub-second tick |
| osc_off | input | 1 | High stops all counting |
| wr_protect | input | 1 | High blocks register writes |
| reg_idx | input | 3 | Byte index |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_idx |

## Verification
Reaching every month end and every February from the ports would take years of ticks if the clock were simply left to run. The bench therefore loads the register port with a state one second before each boundary of interest, then feeds one second of sub-ticks. It does this for every year for the February 28 step, for all twelve months in three years, for all 24 hours in both hour formats, and for every minute value. Sub-second phase behaviour is reached by interleaving partial tick bursts with writes and with the oscillator-off input.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
  localparam int FIELD_W    = 8;
  localparam int IDX_W      = 3;
  localparam int NUM_FIELDS = 7;

  typedef logic [FIELD_W-1:0] bcd_byte_t;

  localparam logic [IDX_W-1:0] IX_SEC  = 3'd0;
  localparam logic [IDX_W-1:0] IX_MIN  = 3'd1;
  localparam logic [IDX_W-1:0] IX_HOUR = 3'd2;
  localparam logic [IDX_W-1:0] IX_WDAY = 3'd3;
  localparam logic [IDX_W-1:0] IX_MDAY = 3'd4;
  localparam logic [IDX_W-1:0] IX_MON  = 3'd5;
  localparam logic [IDX_W-1:0] IX_YEAR = 3'd6;

  // plain BCD increment, no range check
  function automatic bcd_byte_t bcd_inc(input bcd_byte_t v);
    if (v[3:0] >= 4'h9) bcd_inc = {v[7:4] + 4'h1, 4'h0};
    else                bcd_inc = v + 8'h01;
  endfunction

  // increment with wrap at an exact terminal value
  function automatic bcd_byte_t bcd_next(input bcd_byte_t v, input bcd_byte_t last,
                                         input bcd_byte_t first);
    bcd_next = (v == last) ? first : bcd_inc(v);
  endfunction

  // BCD two-digit year divisible by four
  function automatic logic bcd_leap(input bcd_byte_t y);
    if (y[4]) bcd_leap = (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
    else      bcd_leap = (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
  endfunction

  function automatic bcd_byte_t bcd_month_end(input bcd_byte_t m, input logic leap);
    case (m)
      8'h02:                      bcd_month_end = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: bcd_month_end = 8'h30;
      default:                    bcd_month_end = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtcc_prescaler.sv
module rtcc_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sub_tick,
  input  logic phase_clr,
  output logic sec_pulse
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          at_last;

  assign at_last   = (cnt_q == LAST);
  assign sec_pulse = run && sub_tick && !phase_clr && at_last;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (phase_clr) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (run && sub_tick) begin
      cnt_en = 1'b1;
      cnt_d  = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse);
  // R10
  phase_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !phase_clr) |=> $stable(cnt_q));
endmodule

// File: rtl/rtcc_hour_step.sv
module rtcc_hour_step
  import rtcc_pkg::*;
(
  input  bcd_byte_t hour_q,
  output bcd_byte_t hour_nx,
  output logic      day_carry
);
  logic       fmt12;
  logic       pm;
  logic [4:0] hr;

  assign fmt12 = hour_q[6];
  assign pm    = hour_q[5];
  assign hr    = hour_q[4:0];

  always_comb begin
    hour_nx   = hour_q;
    day_carry = 1'b0;
    if (!fmt12) begin
      hour_nx   = bcd_next(hour_q, 8'h23, 8'h00);
      day_carry = (hour_q == 8'h23);
    end else if (hr == 5'h12) begin
      hour_nx = {hour_q[7:5], 5'h01};
    end else if (hr == 5'h11) begin
      hour_nx   = {hour_q[7:6], ~pm, 5'h12};
      day_carry = pm;
    end else begin
      hour_nx = {hour_q[7:5], 5'(bcd_inc({3'b000, hr}))};
    end
  end
endmodule

// File: rtl/rtcc_date_step.sv
module rtcc_date_step
  import rtcc_pkg::*;
(
  input  bcd_byte_t mday_q,
  input  bcd_byte_t mon_q,
  input  bcd_byte_t year_q,
  output bcd_byte_t mday_nx,
  output logic      mday_wrap,
  output bcd_byte_t mon_nx,
  output logic      mon_wrap,
  output bcd_byte_t year_nx
);
  bcd_byte_t last_day;

  assign last_day  = bcd_month_end(mon_q, bcd_leap(year_q));
  assign mday_wrap = (mday_q == last_day);
  assign mday_nx   = bcd_next(mday_q, last_day, 8'h01);
  assign mon_wrap  = (mon_q == 8'h12);
  assign mon_nx    = bcd_next(mon_q, 8'h12, 8'h01);
  assign year_nx   = bcd_next(year_q, 8'h99, 8'h00);
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtcc_pkg::*;
#(
  parameter int SUB_TICKS_PER_SEC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_tick,
  input  logic       osc_off,
  input  logic       wr_protect,
  input  logic [2:0] reg_idx,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  localparam bcd_byte_t RST_VAL [NUM_FIELDS] =
    '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

  bcd_byte_t fld_q  [NUM_FIELDS];
  bcd_byte_t fld_d  [NUM_FIELDS];
  logic      fld_en [NUM_FIELDS];

  logic wr_ok, sec_wr, sec_adv;

  assign wr_ok  = reg_we && !wr_protect && (reg_idx < IDX_W'(NUM_FIELDS));
  assign sec_wr = wr_ok && (reg_idx == IX_SEC);

  rtcc_prescaler #(.DIV(SUB_TICKS_PER_SEC)) u_pre (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (!osc_off),
    .sub_tick  (sub_tick),
    .phase_clr (sec_wr),
    .sec_pulse (sec_adv)
  );

  bcd_byte_t hour_nx;
  logic      hour_day;

  rtcc_hour_step u_hour (
    .hour_q    (fld_q[IX_HOUR]),
    .hour_nx   (hour_nx),
    .day_carry (hour_day)
  );

  bcd_byte_t mday_nx, mon_nx, year_nx;
  logic      mday_wrap, mon_wrap;

  rtcc_date_step u_date (
    .mday_q    (fld_q[IX_MDAY]),
    .mon_q     (fld_q[IX_MON]),
    .year_q    (fld_q[IX_YEAR]),
    .mday_nx   (mday_nx),
    .mday_wrap (mday_wrap),
    .mon_nx    (mon_nx),
    .mon_wrap  (mon_wrap),
    .year_nx   (year_nx)
  );

  // carry chain
  logic c_min, c_hour, c_day, c_mon, c_year;

  assign c_min  = sec_adv && (fld_q[IX_SEC] == 8'h59);
  assign c_hour = c_min   && (fld_q[IX_MIN] == 8'h59);
  assign c_day  = c_hour  && hour_day;
  assign c_mon  = c_day   && mday_wrap;
  assign c_year = c_mon   && mon_wrap;

  always_comb begin
    fld_en[IX_SEC]  = sec_adv;
    fld_d[IX_SEC]   = bcd_next(fld_q[IX_SEC], 8'h59, 8'h00);
    fld_en[IX_MIN]  = c_min;
    fld_d[IX_MIN]   = bcd_next(fld_q[IX_MIN], 8'h59, 8'h00);
    fld_en[IX_HOUR] = c_hour;
    fld_d[IX_HOUR]  = hour_nx;
    fld_en[IX_WDAY] = c_day;
    fld_d[IX_WDAY]  = bcd_next(fld_q[IX_WDAY], 8'h07, 8'h01);
    fld_en[IX_MDAY] = c_day;
    fld_d[IX_MDAY]  = mday_nx;
    fld_en[IX_MON]  = c_mon;
    fld_d[IX_MON]   = mon_nx;
    fld_en[IX_YEAR] = c_year;
    fld_d[IX_YEAR]  = year_nx;
    // a write overrides the counting step for the addressed byte
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (wr_ok && (reg_idx == IDX_W'(i))) begin
        fld_en[i] = 1'b1;
        fld_d[i]  = reg_wdata;
      end
    end
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n)    fld_q[g] <= RST_VAL[g];
      else if (fld_en[g]) fld_q[g] <= fld_d[g];
    end
  end

  assign reg_rdata = (reg_idx < IDX_W'(NUM_FIELDS)) ? fld_q[reg_idx] : '0;

  logic [NUM_FIELDS*FIELD_W-1:0] time_vec;
  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) time_vec[i*FIELD_W +: FIELD_W] = fld_q[i];
  end

  // R10
  osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (osc_off && !reg_we) |=> $stable(time_vec));
  // R11
  wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_protect && !sec_adv) |=> $stable(time_vec));
  // R12
  sec_load_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_we && !wr_protect && reg_idx == IX_SEC) |=> (fld_q[IX_SEC] == $past(reg_wdata)));
  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sec_adv && !reg_we && fld_q[IX_SEC] == 8'h59) |=>
      (fld_q[IX_SEC] == 8'h00 && fld_q[IX_MIN] != $past(fld_q[IX_MIN])));
  // R5
  noon_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sec_adv && !reg_we && fld_q[IX_SEC] == 8'h59 && fld_q[IX_MIN] == 8'h59 &&
     fld_q[IX_HOUR] == 8'h51) |=>
      (fld_q[IX_HOUR] == 8'h72 && $stable(fld_q[IX_MDAY])));
  // R6
  midnight_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sec_adv && !reg_we && fld_q[IX_SEC] == 8'h59 && fld_q[IX_MIN] == 8'h59 &&
     fld_q[IX_HOUR] == 8'h71) |=>
      (fld_q[IX_HOUR] == 8'h52 && fld_q[IX_MDAY] != $past(fld_q[IX_MDAY])));
endmodule

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
  localparam int DIV = 4;

  logic       clk, rst_n, sub_tick, osc_off, wr_protect, reg_we;
  logic [2:0] reg_idx;
  logic [7:0] reg_wdata, reg_rdata;

  int n_chk = 0;
  int n_err = 0;

  rtc_calendar_core #(.SUB_TICKS_PER_SEC(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .osc_off(osc_off),
    .wr_protect(wr_protect), .reg_idx(reg_idx), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [7:0] enc12(input int h24);
    int hh;
    hh = (h24 % 12 == 0) ? 12 : h24 % 12;
    return 8'h40 | ((h24 >= 12) ? 8'h20 : 8'h00) | bcd(hh);
  endfunction

  function automatic int mlen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    reg_idx = 3'(idx); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [7:0] d);
    reg_idx = 3'(idx);
    #1;
    d = reg_rdata;
  endtask

  task automatic set_all(input logic [7:0] s, mi, h, w, md, mo, y);
    wr(6, y); wr(5, mo); wr(4, md); wr(3, w); wr(2, h); wr(1, mi); wr(0, s);
  endtask

  task automatic subticks(input int n);
    for (int i = 0; i < n; i++) begin
      sub_tick = 1'b1;
      @(negedge clk);
    end
    sub_tick = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] rst_exp [7];
    rst_exp = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
    rst_n = 1'b0; sub_tick = 1'b0; osc_off = 1'b0; wr_protect = 1'b0;
    reg_we = 1'b0; reg_idx = 3'd0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values and unused index
    for (int i = 0; i < 7; i++) begin
      rd(i, v); check("R1 reset", v, rst_exp[i]);
    end
    rd(7, v); check("R1 index7", v, 8'h00);

    // R2 one second per DIV sub-ticks
    wr(0, 8'h10);
    subticks(DIV - 1); rd(0, v); check("R2 partial", v, 8'h10);
    subticks(1);       rd(0, v); check("R2 full", v, 8'h11);

    // R12 minute write keeps phase, seconds write restarts it
    subticks(2); wr(1, 8'h20); subticks(DIV - 2); rd(0, v); check("R12 phase kept", v, 8'h12);
    rd(1, v); check("R12 min load", v, 8'h20);
    subticks(2); wr(0, 8'h30); subticks(DIV - 2); rd(0, v); check("R12 phase reset", v, 8'h30);
    subticks(2); rd(0, v); check("R12 after reset", v, 8'h31);

    // R10 oscillator off freezes fields and phase
    subticks(2);
    osc_off = 1'b1; subticks(3 * DIV);
    rd(0, v); check("R10 sec frozen", v, 8'h31);
    osc_off = 1'b0;
    subticks(DIV - 3); rd(0, v); check("R10 phase held", v, 8'h31);
    subticks(1);       rd(0, v); check("R10 resume", v, 8'h32);

    // R11 write protect
    set_all(8'h05, 8'h06, 8'h07, 8'h02, 8'h08, 8'h09, 8'h10);
    wr_protect = 1'b1;
    for (int i = 0; i < 7; i++) wr(i, 8'h77);
    wr_protect = 1'b0;
    rd(0, v); check("R11 sec", v, 8'h05);
    rd(2, v); check("R11 hour", v, 8'h07);
    rd(6, v); check("R11 year", v, 8'h10);

    // R13 illegal BCD kept
    wr(0, 8'h7A); rd(0, v); check("R13 sec", v, 8'h7A);
    wr(4, 8'h45); rd(4, v); check("R13 mday", v, 8'h45);

    // R3 minute sweep
    for (int m = 0; m < 60; m++) begin
      set_all(8'h59, bcd(m), 8'h05, 8'h01, 8'h10, 8'h05, 8'h20);
      subticks(DIV);
      rd(0, v); check("R3 sec", v, 8'h00);
      rd(1, v); check("R3 min", v, bcd((m + 1) % 60));
      rd(2, v); check("R3 hour", v, (m == 59) ? 8'h06 : 8'h05);
    end

    // R4 24-hour sweep, R5/R6 12-hour sweep
    for (int h = 0; h < 24; h++) begin
      set_all(8'h59, 8'h59, bcd(h), 8'h01, 8'h10, 8'h05, 8'h20);
      subticks(DIV);
      rd(2, v); check("R4 hour24", v, bcd((h + 1) % 24));
      rd(4, v); check("R4 date", v, (h == 23) ? 8'h11 : 8'h10);
      set_all(8'h59, 8'h59, enc12(h), 8'h01, 8'h10, 8'h05, 8'h20);
      subticks(DIV);
      rd(2, v); check((h == 23) ? "R6 hour12" : "R5 hour12", v, enc12((h + 1) % 24));
      rd(4, v); check((h == 23) ? "R6 date" : "R5 date", v, (h == 23) ? 8'h11 : 8'h10);
    end

    // R7 day-of-week wrap
    for (int w = 1; w <= 7; w++) begin
      set_all(8'h59, 8'h59, 8'h23, bcd(w), 8'h10, 8'h05, 8'h20);
      subticks(DIV);
      rd(3, v); check("R7 wday", v, bcd((w == 7) ? 1 : w + 1));
    end

    // R8 month ends in three years
    for (int yi = 0; yi < 3; yi++) begin
      int y;
      y = (yi == 0) ? 0 : (yi == 1) ? 23 : 99;
      for (int m = 1; m <= 12; m++) begin
        set_all(8'h59, 8'h59, 8'h23, 8'h01, bcd(mlen(m, y)), bcd(m), bcd(y));
        subticks(DIV);
        rd(4, v); check("R8 mday wrap", v, 8'h01);
        rd(5, v); check("R8 month", v, bcd((m == 12) ? 1 : m + 1));
        rd(6, v); check("R8 year", v, bcd((m == 12) ? (y + 1) % 100 : y));
      end
    end

    // R9 February 28 in every year
    for (int y = 0; y < 100; y++) begin
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, bcd(y));
      subticks(DIV);
      rd(4, v); check("R9 feb28", v, (y % 4 == 0) ? 8'h29 : 8'h01);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule